// File: doc/BRIEF.md
# Channel Address Translator

This block turns a system physical address into the address seen by one memory channel. The caller supplies the address, the memory controller and the channel that an earlier routing stage picked. The block then searches that controller's eight target ranges for the one holding the address. It subtracts the per-channel offset of that range and removes the socket and channel interleave. The result is a channel-local address, together with the socket and channel way counts of the range.

Each range is described by three 32-bit words: a base word, a wayness word and one offset word per channel. They are loaded through a simple write port. A request starts with a one-cycle `start` pulse. Removing the interleave needs a division by the way count, and one of the channel way counts is three. A shared bit-serial divider does this division over several cycles. When the work is done, `done` pulses for one cycle, and `miss` tells whether any range matched.

Top module: `chan_addr_xlat`

## Requirements
- R1: After reset `busy`, `done` and `miss` are low, and `chanAddr`, `sktWays` and `chanWays` are zero.
- R2: Entry i of the selected controller matches when lo ≤ address ≤ hi. lo is base-word bits [31:12] placed at address bit 26 and up, with zeros below. hi is wayness-word bits [31:12] placed the same way, with bits [25:0] all ones. Both bounds are inclusive. When several entries match, the lowest index wins.
- R3: When no entry matches, `done` pulses with `miss` high, and `chanAddr`, `sktWays` and `chanWays` keep their previous values. `miss` clears on the next accepted `start`.
- R4: For a matched entry, `sktWays` equals 1 shifted left by wayness bits [11:10], and `chanWays` equals wayness bits [9:8] plus one. Both are valid while `done` is high.
- R5: Base-word bits [5:4] give the socket granularity and bits [7:6] give the channel granularity. Codes 0, 1, 2 and 3 select address bit 6, 8, 12 and 30.
- R6: Before the interleave is removed, the offset word of the matched entry for the selected controller and channel is subtracted from the address. The offset is bits [23:4] of that word, placed at address bit 26. The subtraction wraps modulo the address width.
- R7: Removing one interleave with granularity bit g and way count w takes the value's bits from g upward, divides them by w, places the quotient back at bit g, and fills bits below g from a low-bit source.
- R8: When the channel way count is 3 and the socket granularity bit is above the channel granularity bit, the channel interleave is removed first and the socket interleave second. Each step takes its low bits from the value it is working on.
- R9: In every other case the socket interleave is removed first and the channel interleave second. Both steps take their low bits from the original system address.
- R10: A write with `cfgWe` high stores `cfgData` into entry `cfgIdx` of controller `cfgMc`. `cfgKind` selects the word: 0 is the base word, 1 is the wayness word, and 2 is the offset word of channel `cfgCh`.
- R11: `start` is taken only when `busy` is low. `busy` is high from the next cycle until the cycle `done` pulses. `done` lasts exactly one cycle. A `start` while busy has no effect.
- R12: Only the ranges of controller `mcSel` are searched, and only the offset of channel `chSel` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| sysAddr | input | 46 | System address of the request |
| mcSel | input | 1 | Controller chosen for the request |
| chSel | input | 2 | Channel chosen for the request |
| cfgWe | input | 1 | Configuration write enable |
| cfgKind | input | 2 | Word kind: 0 base, 1 wayness, 2 channel offset |
| cfgMc | input | 1 | Controller of the written word |
| cfgCh | input | 2 | Channel of an offset word |
| cfgIdx | input | 3 | Range entry of the written word |
| cfgData | input | 32 | Written word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| miss | output | 1 | No range matched the last request |
| chanAddr | output | 46 | Channel-local address |
| sktWays | output | 4 | Socket way count of the matched range |
| chanWays | output | 4 | Channel way count of the matched range |

## Verification
The bench goes after the step ordering, with three-way channel interleave and the socket granularity both above and below the channel one. A design that ignored the ordering rule, or took its low bits from the wrong source, would return a channel address that is wrong in either the quotient bits or the bits below the granularity. Inclusive range ends, overlapping entries and granularity 30 are each hit on purpose. A design with off-by-one bounds or reversed priority would, respectively, miss an edge address or report the way counts of the wrong entry. Misses and a `start` pulse sent while busy are also checked: a faulty design would overwrite the held result or start a second translation.

// File: rtl/chan_addr_xlat_pkg.sv
package chan_addr_xlat_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldReq;    // capture request fields
    logic ldMatch;  // capture matched entry and apply offset
    logic divGo;    // launch the divider
    logic merge;    // fold the quotient back into the work value
    logic stepSel;  // 0: first interleave step, 1: second
  } xlatStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_STEP_A,
    ST_WAIT_A,
    ST_STEP_B,
    ST_WAIT_B
  } xlatState_t;

  localparam logic [1:0] KIND_BASE = 2'd0;
  localparam logic [1:0] KIND_WAY  = 2'd1;
  localparam logic [1:0] KIND_OFF  = 2'd2;

  // Granularity code to address bit position (monotonic in the code)
  function automatic logic [4:0] granPos(input logic [1:0] code);
    case (code)
      2'd0:    granPos = 5'd6;
      2'd1:    granPos = 5'd8;
      2'd2:    granPos = 5'd12;
      default: granPos = 5'd30;
    endcase
  endfunction

endpackage

// File: rtl/chan_addr_xlat_cfg.sv
module chan_addr_xlat_cfg #(
  parameter int NUM_MC  = 2,
  parameter int NUM_CH  = 3,
  parameter int NUM_ENT = 8,
  parameter int MC_W    = 1,
  parameter int CH_W    = 2,
  parameter int IDX_W   = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          we,
  input  logic [1:0]                    kind,
  input  logic [MC_W-1:0]               wMc,
  input  logic [CH_W-1:0]               wCh,
  input  logic [IDX_W-1:0]              wIdx,
  input  logic [31:0]                   wData,
  input  logic [MC_W-1:0]               rdMc,
  input  logic [CH_W-1:0]               rdCh,
  output logic [NUM_ENT-1:0][23:0]      baseRow,
  output logic [NUM_ENT-1:0][23:0]      wayRow,
  output logic [NUM_ENT-1:0][19:0]      offRow
);
  import chan_addr_xlat_pkg::*;

  // Only the fields the block uses are kept.
  // base: [23:4] low bound field, [3:2] channel gran code, [1:0] socket gran code
  // way : [23:4] high bound field, [3:2] socket ways code, [1:0] channel ways code
  logic [23:0] baseMem [NUM_MC][NUM_ENT];
  logic [23:0] wayMem  [NUM_MC][NUM_ENT];
  logic [19:0] offMem  [NUM_MC][NUM_CH][NUM_ENT];

  logic unusedCfgBits;
  assign unusedCfgBits = ^wData[3:0];

  logic wMcOk, wChOk, wIdxOk;
  assign wMcOk  = (int'(wMc) < NUM_MC);
  assign wChOk  = (int'(wCh) < NUM_CH);
  assign wIdxOk = (int'(wIdx) < NUM_ENT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int m = 0; m < NUM_MC; m++) begin
        for (int e = 0; e < NUM_ENT; e++) begin
          baseMem[m][e] <= '0;
          wayMem[m][e]  <= '0;
          for (int c = 0; c < NUM_CH; c++) offMem[m][c][e] <= '0;
        end
      end
    end else if (we && wMcOk && wIdxOk) begin
      case (kind)
        KIND_BASE: baseMem[wMc][wIdx] <= {wData[31:12], wData[7:6], wData[5:4]};
        KIND_WAY:  wayMem[wMc][wIdx]  <= {wData[31:12], wData[11:10], wData[9:8]};
        KIND_OFF:  if (wChOk) offMem[wMc][wCh][wIdx] <= wData[23:4];
        default: ;
      endcase
    end
  end

  logic [MC_W-1:0] rMc;
  logic [CH_W-1:0] rCh;
  assign rMc = (int'(rdMc) < NUM_MC) ? rdMc : '0;
  assign rCh = (int'(rdCh) < NUM_CH) ? rdCh : '0;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_row
    assign baseRow[e] = baseMem[rMc][e];
    assign wayRow[e]  = wayMem[rMc][e];
    assign offRow[e]  = offMem[rMc][rCh][e];
  end

endmodule

// File: rtl/chan_addr_xlat_div.sv
module chan_addr_xlat_div #(
  parameter int W    = 46,
  parameter int DV_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            go,
  input  logic [W-1:0]    dividend,
  input  logic [DV_W-1:0] divisor,
  output logic [W-1:0]    quot,
  output logic            fin
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     quoQ;
  logic [DV_W-1:0]  remQ;
  logic [DV_W-1:0]  divQ;
  logic [DV_W:0]    trial;
  logic [DV_W:0]    diff;
  logic             geq;

  // Restoring division, one quotient bit per cycle, MSB first
  assign trial = {remQ, quoQ[W-1]};
  assign geq   = (trial >= {1'b0, divQ});
  assign diff  = trial - {1'b0, divQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      quoQ <= '0;
      remQ <= '0;
      divQ <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quoQ <= dividend;
        remQ <= '0;
        divQ <= divisor;
        cnt  <= CNT_W'(W);
      end else if (cnt != '0) begin
        quoQ <= {quoQ[W-2:0], geq};
        remQ <= geq ? diff[DV_W-1:0] : trial[DV_W-1:0];
        cnt  <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) fin <= 1'b1;
      end
    end
  end

  assign quot = quoQ;

endmodule

// File: rtl/chan_addr_xlat_dp.sv
module chan_addr_xlat_dp
  import chan_addr_xlat_pkg::*;
#(
  parameter int ADDR_W  = 46,
  parameter int NUM_MC  = 2,
  parameter int NUM_CH  = 3,
  parameter int NUM_ENT = 8,
  parameter int MC_W    = 1,
  parameter int CH_W    = 2,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrb_t         strb,
  input  logic [ADDR_W-1:0] sysAddr,
  input  logic [MC_W-1:0]   mcSel,
  input  logic [CH_W-1:0]   chSel,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [MC_W-1:0]   cfgMc,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  output logic              hit,
  output logic              divFin,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [3:0]        sktWays,
  output logic [3:0]        chanWays
);
  localparam int LOW_W = 26;
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << LOW_W) - ADDR_W'(1);

  logic [ADDR_W-1:0] addrQ;
  logic [MC_W-1:0]   mcQ;
  logic [CH_W-1:0]   chQ;
  logic [ADDR_W-1:0] workQ;
  logic [1:0]        sktCodeQ, chnCodeQ;
  logic [3:0]        sktWaysQ, chnWaysQ;
  logic              chanFirstQ;

  logic [NUM_ENT-1:0][23:0] baseRow;
  logic [NUM_ENT-1:0][23:0] wayRow;
  logic [NUM_ENT-1:0][19:0] offRow;

  chan_addr_xlat_cfg #(
    .NUM_MC(NUM_MC), .NUM_CH(NUM_CH), .NUM_ENT(NUM_ENT),
    .MC_W(MC_W), .CH_W(CH_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rstN(rstN),
    .we(cfgWe), .kind(cfgKind), .wMc(cfgMc), .wCh(cfgCh), .wIdx(cfgIdx), .wData(cfgData),
    .rdMc(mcQ), .rdCh(chQ),
    .baseRow(baseRow), .wayRow(wayRow), .offRow(offRow)
  );

  // Range compare, all entries in parallel
  logic [NUM_ENT-1:0] hitVec;
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    logic [ADDR_W-1:0] loA, hiA;
    assign loA       = ADDR_W'(baseRow[e][23:4]) << LOW_W;
    assign hiA       = (ADDR_W'(wayRow[e][23:4]) << LOW_W) | LOW_MASK;
    assign hitVec[e] = (addrQ >= loA) && (addrQ <= hiA);
  end

  // Lowest index wins
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (hitVec[e]) selIdx = IDX_W'(e);
    end
  end
  assign hit = |hitVec;

  logic [23:0]       selBase, selWay;
  logic [ADDR_W-1:0] selOff;
  assign selBase = baseRow[selIdx];
  assign selWay  = wayRow[selIdx];
  assign selOff  = ADDR_W'(offRow[selIdx]) << LOW_W;

  // Interleave step operands
  logic              useChn;
  logic [4:0]        stepG;
  logic [3:0]        stepW;
  logic [ADDR_W-1:0] lowSrc, lowMask, merged, quot;

  assign useChn  = chanFirstQ ^ strb.stepSel;
  assign stepG   = granPos(useChn ? chnCodeQ : sktCodeQ);
  assign stepW   = useChn ? chnWaysQ : sktWaysQ;
  assign lowSrc  = chanFirstQ ? workQ : addrQ;
  assign lowMask = (ADDR_W'(1) << stepG) - ADDR_W'(1);
  assign merged  = (quot << stepG) | (lowSrc & lowMask);

  chan_addr_xlat_div #(.W(ADDR_W), .DV_W(4)) u_div (
    .clk(clk), .rstN(rstN),
    .go(strb.divGo),
    .dividend(workQ >> stepG),
    .divisor(stepW),
    .quot(quot),
    .fin(divFin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      mcQ        <= '0;
      chQ        <= '0;
      workQ      <= '0;
      sktCodeQ   <= '0;
      chnCodeQ   <= '0;
      sktWaysQ   <= '0;
      chnWaysQ   <= '0;
      chanFirstQ <= 1'b0;
    end else begin
      if (strb.ldReq) begin
        addrQ <= sysAddr;
        mcQ   <= mcSel;
        chQ   <= chSel;
      end
      if (strb.ldMatch) begin
        sktCodeQ   <= selBase[1:0];
        chnCodeQ   <= selBase[3:2];
        sktWaysQ   <= 4'd1 << selWay[3:2];
        chnWaysQ   <= {2'b00, selWay[1:0]} + 4'd1;
        chanFirstQ <= (selWay[1:0] == 2'd2) && (selBase[1:0] > selBase[3:2]);
        workQ      <= addrQ - selOff;
      end
      if (strb.merge) workQ <= merged;
    end
  end

  assign chanAddr = workQ;
  assign sktWays  = sktWaysQ;
  assign chanWays = chnWaysQ;

endmodule

// File: rtl/chan_addr_xlat_ctrl.sv
module chan_addr_xlat_ctrl
  import chan_addr_xlat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      hit,
  input  logic      divFin,
  output xlatStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      miss
);
  xlatState_t state, nxt;
  logic       doneQ, missQ;

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      ST_IDLE: if (start) begin
        strb.ldReq = 1'b1;
        nxt        = ST_SEARCH;
      end
      ST_SEARCH: begin
        if (hit) begin
          strb.ldMatch = 1'b1;
          nxt          = ST_STEP_A;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_STEP_A: begin
        strb.divGo = 1'b1;
        nxt        = ST_WAIT_A;
      end
      ST_WAIT_A: if (divFin) begin
        strb.merge = 1'b1;
        nxt        = ST_STEP_B;
      end
      ST_STEP_B: begin
        strb.stepSel = 1'b1;
        strb.divGo   = 1'b1;
        nxt          = ST_WAIT_B;
      end
      ST_WAIT_B: begin
        strb.stepSel = 1'b1;
        if (divFin) begin
          strb.merge = 1'b1;
          nxt        = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
      missQ <= 1'b0;
    end else begin
      state <= nxt;
      doneQ <= ((state == ST_SEARCH) && !hit) || ((state == ST_WAIT_B) && divFin);
      if ((state == ST_IDLE) && start)       missQ <= 1'b0;
      else if ((state == ST_SEARCH) && !hit) missQ <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;
  assign miss = missQ;

endmodule

// File: rtl/chan_addr_xlat.sv
module chan_addr_xlat
  import chan_addr_xlat_pkg::*;
#(
  parameter int ADDR_W  = 46,  // at least 46: range fields reach bit 45
  parameter int NUM_MC  = 2,
  parameter int NUM_CH  = 3,
  parameter int NUM_ENT = 8,
  localparam int MC_W   = (NUM_MC > 1) ? $clog2(NUM_MC) : 1,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] sysAddr,
  input  logic [MC_W-1:0]   mcSel,
  input  logic [CH_W-1:0]   chSel,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [MC_W-1:0]   cfgMc,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  output logic              busy,
  output logic              done,
  output logic              miss,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [3:0]        sktWays,
  output logic [3:0]        chanWays
);
  xlatStrb_t strb;
  logic      hit, divFin;

  chan_addr_xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .hit(hit), .divFin(divFin),
    .strb(strb), .busy(busy), .done(done), .miss(miss)
  );

  chan_addr_xlat_dp #(
    .ADDR_W(ADDR_W), .NUM_MC(NUM_MC), .NUM_CH(NUM_CH), .NUM_ENT(NUM_ENT),
    .MC_W(MC_W), .CH_W(CH_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .sysAddr(sysAddr), .mcSel(mcSel), .chSel(chSel),
    .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgMc(cfgMc), .cfgCh(cfgCh),
    .cfgIdx(cfgIdx), .cfgData(cfgData),
    .hit(hit), .divFin(divFin),
    .chanAddr(chanAddr), .sktWays(sktWays), .chanWays(chanWays)
  );

endmodule

// File: rtl/chan_addr_xlat_chk.sv
module chan_addr_xlat_chk #(
  parameter int ADDR_W = 46
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              miss,
  input logic [ADDR_W-1:0] chanAddr
);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_miss_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(miss) |-> done);

  p_miss_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> !miss);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(chanAddr));

endmodule

bind chan_addr_xlat chan_addr_xlat_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .miss(miss), .chanAddr(chanAddr)
);

// File: tb/sim_chan_addr_xlat.sv
`timescale 1ns/1ps
module sim_chan_addr_xlat;
  localparam int AW = 46;
  localparam logic [63:0] M46 = (64'd1 << AW) - 64'd1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] sysAddr = '0;
  logic [0:0]    mcSel = '0;
  logic [1:0]    chSel = '0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgKind = '0;
  logic [0:0]    cfgMc = '0;
  logic [1:0]    cfgCh = '0;
  logic [2:0]    cfgIdx = '0;
  logic [31:0]   cfgData = '0;
  logic          busy, done, miss;
  logic [AW-1:0] chanAddr;
  logic [3:0]    sktWays, chanWays;

  chan_addr_xlat u0 (
    .clk(clk), .rstN(rstN), .start(start), .sysAddr(sysAddr), .mcSel(mcSel),
    .chSel(chSel), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgMc(cfgMc), .cfgCh(cfgCh),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .busy(busy), .done(done), .miss(miss),
    .chanAddr(chanAddr), .sktWays(sktWays), .chanWays(chanWays)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  // ---------------- reference model from the requirements ----------------
  function automatic int gpos(input int code);
    case (code)
      0: return 6;
      1: return 8;
      2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic logic [63:0] stepf(input logic [63:0] x, input int g, input int w,
                                        input logic [63:0] low);
    logic [63:0] q;
    q = (x >> g) / 64'(w);
    return ((q << g) | (low & ((64'd1 << g) - 64'd1))) & M46;
  endfunction

  function automatic logic [63:0] refAddr(input logic [63:0] addr, input int sg, input int cg,
                                          input int sw, input int cw, input logic [63:0] offF);
    logic [63:0] a0, a1;
    int gs, gc, ws, wc;
    gs = gpos(sg); gc = gpos(cg); ws = 1 << sw; wc = cw + 1;
    a0 = (addr - (offF << 26)) & M46;
    if (wc == 3 && gs > gc) begin
      a1 = stepf(a0, gc, wc, a0);
      return stepf(a1, gs, ws, a1);
    end
    a1 = stepf(a0, gs, ws, addr);
    return stepf(a1, gc, wc, addr);
  endfunction

  // ---------------- stimulus helpers ----------------
  task automatic wrCfg(input int kind, input int mc, input int ch, input int idx, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = kind[1:0]; cfgMc = mc[0:0]; cfgCh = ch[1:0];
    cfgIdx = idx[2:0]; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setEntry(input int mc, input int idx, input logic [19:0] loF, input logic [19:0] hiF,
                          input int sg, input int cg, input int sw, input int cw);
    wrCfg(0, mc, 0, idx, {loF, 4'b0, cg[1:0], sg[1:0], 4'b0});
    wrCfg(1, mc, 0, idx, {hiF, sw[1:0], cw[1:0], 8'b0});
  endtask

  task automatic setOff(input int mc, input int ch, input int idx, input logic [19:0] offF);
    wrCfg(2, mc, ch, idx, {8'b0, offF, 4'b0});
  endtask

  task automatic clearAll();
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 8; e++) begin
        wrCfg(0, m, 0, e, 32'hFFFFF000);  // low bound above high bound: never matches
        wrCfg(1, m, 0, e, 32'h0);
        for (int c = 0; c < 3; c++) setOff(m, c, e, 20'h0);
      end
    end
  endtask

  task automatic runReq(input logic [63:0] addr, input int mc, input int ch);
    @(negedge clk);
    start = 1'b1; sysAddr = addr[AW-1:0]; mcSel = mc[0:0]; chSel = ch[1:0];
    @(negedge clk);
    start = 1'b0;
    check("R11 busy after start", 64'(busy), 64'd1);
    for (int i = 0; i < 400; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R11 done seen", 64'(done), 64'd1);
  endtask

  task automatic expectHit(input string tag, input logic [63:0] addr, input int mc, input int ch,
                           input int sg, input int cg, input int sw, input int cw,
                           input logic [63:0] offF);
    runReq(addr, mc, ch);
    check({tag, " miss low"}, 64'(miss), 64'd0);
    check({tag, " chanAddr"}, 64'(chanAddr), refAddr(addr, sg, cg, sw, cw, offF));
    check({tag, " R4 sktWays"}, 64'(sktWays), 64'(1 << sw));
    check({tag, " R4 chanWays"}, 64'(chanWays), 64'(cw + 1));
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 miss", 64'(miss), 64'd0);
    check("R1 chanAddr", 64'(chanAddr), 64'd0);
    check("R1 sktWays", 64'(sktWays), 64'd0);
    check("R1 chanWays", 64'(chanWays), 64'd0);
  endtask

  task automatic testIdentity();
    clearAll();
    setEntry(0, 0, 20'h1, 20'h3, 0, 0, 0, 0);  // R10 write port
    expectHit("R2 R10 identity", 64'h5123456, 0, 0, 0, 0, 0, 0, 0);
    check("R2 identity value", 64'(chanAddr), 64'h5123456);
  endtask

  task automatic testChanFirst();
    clearAll();
    // three channel ways, socket bit 12 above channel bit 8
    setEntry(0, 2, 20'h10, 20'h3F, 2, 1, 1, 2);
    expectHit("R8 chan first", 64'h9ABCDEF0, 0, 0, 2, 1, 1, 2, 0);
    expectHit("R8 R7 chan first b", 64'hC0FFEE55, 0, 0, 2, 1, 1, 2, 0);
  endtask

  task automatic testSockFirst();
    clearAll();
    // three channel ways, socket bit 6 below channel bit 8
    setEntry(0, 2, 20'h10, 20'h3F, 0, 1, 1, 2);
    expectHit("R9 sock first low gran", 64'h9ABCDEF0, 0, 0, 0, 1, 1, 2, 0);
    // two channel ways, socket bit above: still socket first
    setEntry(0, 2, 20'h10, 20'h3F, 2, 1, 1, 1);
    expectHit("R9 sock first two ways", 64'h9ABCDEF0, 0, 0, 2, 1, 1, 1, 0);
  endtask

  task automatic testOffset();
    clearAll();
    setEntry(1, 5, 20'h20, 20'h2F, 1, 0, 0, 1);
    setOff(1, 0, 5, 20'h1);
    setOff(1, 2, 5, 20'h3);
    expectHit("R6 R12 offset ch2", 64'hA1234567, 1, 2, 1, 0, 0, 1, 64'h3);
    expectHit("R6 R12 offset ch0", 64'hA1234567, 1, 0, 1, 0, 0, 1, 64'h1);
  endtask

  task automatic testGran30();
    clearAll();
    setEntry(0, 6, 20'h100, 20'h1FF, 3, 0, 2, 0);
    expectHit("R5 gran30", 64'h5_4321_0FED, 0, 0, 3, 0, 2, 0, 0);
  endtask

  task automatic testWays();
    clearAll();
    setEntry(0, 1, 20'h4, 20'h7, 1, 0, 3, 3);
    expectHit("R4 max ways", 64'h1_7654_321, 0, 0, 1, 0, 3, 3, 0);
  endtask

  task automatic testMiss();
    logic [63:0] held;
    clearAll();
    setEntry(0, 0, 20'h1, 20'h3, 1, 0, 1, 0);
    expectHit("R3 before miss", 64'h6000040, 0, 0, 1, 0, 1, 0, 0);
    held = 64'(chanAddr);
    runReq(64'h3000_0000_0000, 0, 0);
    check("R3 miss flag", 64'(miss), 64'd1);
    check("R3 chanAddr held", 64'(chanAddr), held);
    check("R3 sktWays held", 64'(sktWays), 64'd2);
    runReq(64'h6000040, 1, 0);
    check("R12 other controller misses", 64'(miss), 64'd1);
    expectHit("R3 miss clears", 64'h6000040, 0, 0, 1, 0, 1, 0, 0);
  endtask

  task automatic testBoundary();
    clearAll();
    setEntry(0, 0, 20'h1, 20'h3, 0, 0, 0, 0);
    expectHit("R2 upper edge", 64'hFFFFFFF, 0, 0, 0, 0, 0, 0, 0);
    expectHit("R2 lower edge", 64'h4000000, 0, 0, 0, 0, 0, 0, 0);
    runReq(64'h10000000, 0, 0);
    check("R2 above upper edge", 64'(miss), 64'd1);
    runReq(64'h3FFFFFF, 0, 0);
    check("R2 below lower edge", 64'(miss), 64'd1);
  endtask

  task automatic testPriority();
    clearAll();
    setEntry(0, 3, 20'h800, 20'h8FF, 0, 0, 1, 0);
    setEntry(0, 4, 20'h800, 20'h8FF, 0, 0, 2, 0);
    expectHit("R2 lowest index wins", 64'h21_2345_6780, 0, 0, 0, 0, 1, 0, 0);
    wrCfg(0, 0, 0, 3, 32'hFFFFF000);
    expectHit("R2 next entry", 64'h21_2345_6780, 0, 0, 0, 0, 2, 0, 0);
  endtask

  task automatic testBusyStart();
    int extraDone;
    clearAll();
    setEntry(0, 2, 20'h10, 20'h3F, 2, 1, 1, 2);
    setEntry(1, 0, 20'h10, 20'h3F, 0, 0, 0, 0);
    @(negedge clk);
    start = 1'b1; sysAddr = AW'(64'h9ABCDEF0); mcSel = 1'b0; chSel = 2'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; sysAddr = AW'(64'h5555_5555); mcSel = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R11 done for first request", 64'(done), 64'd1);
    check("R11 first result kept", 64'(chanAddr), refAddr(64'h9ABCDEF0, 2, 1, 1, 2, 0));
    @(negedge clk);
    check("R11 done one cycle", 64'(done), 64'd0);
    extraDone = 0;
    for (int i = 0; i < 150; i++) begin
      if (done || busy) extraDone++;
      @(negedge clk);
    end
    check("R11 start while busy ignored", 64'(extraDone), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdentity();
    testChanFirst();
    testSockFirst();
    testOffset();
    testGran30();
    testWays();
    testMiss();
    testBoundary();
    testPriority();
    testBusyStart();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule